// File: doc/BRIEF.md
# Slot Hotplug Event Controller

This block keeps the per-slot bookkeeping for a bus segment on which devices can be inserted and removed while the system runs. An insertion, a removal request or a boot-time presence report for a numbered slot arrives as a single-cycle event. The block turns that event into slot masks that firmware can read. Insertions and removal requests also raise a pending general-purpose event flag, which the interrupt logic outside this block combines into the system control interrupt.

Firmware reads four slot masks through a small word-addressed register port: hot-removable present slots, removals waiting for service, the removable-slot mask, and a feature word. It completes a removal by writing a slot mask to the eject register. The block then services only the lowest set slot in that mask and emits a one-cycle eject strobe carrying the slot number, which the device-teardown logic acts on.

A platform reset request first drains every outstanding removal, one slot per cycle and lowest slot first, with a strobe for each. After that it rebuilds the removable and present masks from the static board inputs.

Top module: `hp_slot_event_ctrl`

## Requirements
- R1: Reading address 0 returns the present mask ANDed with the removable mask, zero-extended to 32 bits.
- R2: Address 1 reads the pending-removal mask, address 3 reads the removable mask, and address 2 (eject) and any unmapped address read as zero.
- R3: An event of kind 1 (hot-add) for slot s sets present bit s and sets the event flag, which reads as bit 1 at address 4 and drives `gpe_sts`.
- R4: An event of kind 2 (hot-remove) for slot s sets pending bit s and sets the event flag. Present bit s is left unchanged.
- R5: An event of kind 0 (cold-plug) for slot s sets present bit s and leaves the event flag unchanged.
- R6: A write of a nonzero value to address 2 takes the lowest set bit s of the written value and clears pending bit s. It also clears present bit s if slot s is removable. If slot s is fixed, present bit s is kept. In the cycle after the write, `eject_strobe` is high for one cycle with `eject_slot` = s.
- R7: A write of zero to address 2 changes no mask and produces no strobe.
- R8: Writing address 4 with bit 1 set clears the event flag, and other bits have no effect. When an event that sets the flag arrives in the same cycle, the flag stays set.
- R9: A cycle with `plat_reset_req` high starts a drain. In each following cycle the lowest pending slot is ejected, with its strobe. Once no slot is pending, the removable mask is loaded with the inverse of `fixed_mask` and the present mask with `occupied`.
- R10: While `rst_n` is low, present takes `occupied`, removable takes the inverse of `fixed_mask`, and pending, the event flag and the strobe are cleared.
- R11: An event with kind 3 or with a slot number of NUM_SLOTS or above is ignored. Events and register writes that arrive while a drain is running are also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_valid | input | 1 | Slot event present this cycle |
| ev_kind | input | 2 | 0 cold-plug, 1 hot-add, 2 hot-remove, 3 ignored |
| ev_slot | input | SLOT_W | Slot number of the event |
| fixed_mask | input | NUM_SLOTS | Slots whose devices cannot be hot-removed |
| occupied | input | NUM_SLOTS | Slots holding a device, used at reset and rebuild |
| plat_reset_req | input | 1 | Start drain and rebuild |
| reg_addr | input | 3 | Register word address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| gpe_sts | output | 1 | Hotplug event flag |
| eject_strobe | output | 1 | One-cycle eject pulse |
| eject_slot | output | SLOT_W | Slot being ejected |

## Verification
The bench builds the block with NUM_SLOTS = 6, so the slot field is 3 bits wide. Slot numbers 6 and 7 can then be driven, which makes the out-of-range filtering observable. The highest mask bit also sits below bit 31, so the zero extension of every read is exercised. The fixed mask marks slots 2 and 5, which puts a fixed slot inside the eject path. During the drain, the `occupied` input is changed between power-on and the platform reset, so the rebuilt masks are visibly taken from the inputs and not held over.

// File: rtl/hp_pkg.sv
// Shared types and constants for the slot hotplug event controller.
// Assumes register data is 32 bits and at most 32 slots are tracked.
package hp_pkg;

    localparam int DATA_W  = 32;
    localparam int GPE_BIT = 1;

    typedef enum logic [1:0] {
        EV_COLD   = 2'd0,
        EV_ADD    = 2'd1,
        EV_REMOVE = 2'd2,
        EV_RSVD   = 2'd3
    } hp_ev_e;

    localparam logic [2:0] CSR_UP    = 3'd0;
    localparam logic [2:0] CSR_DOWN  = 3'd1;
    localparam logic [2:0] CSR_EJECT = 3'd2;
    localparam logic [2:0] CSR_RMV   = 3'd3;
    localparam logic [2:0] CSR_GPE   = 3'd4;

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_DRAIN = 1'b1
    } hp_state_e;

endpackage

// File: rtl/hp_lsb_pick.sv
// Lowest-set-bit picker: returns a one-hot of the least significant set
// bit, its index, and whether any bit was set. Pure combinational.
module hp_lsb_pick #(
    parameter int W     = 32,
    parameter int IDX_W = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]     vec,
    output logic             found,
    output logic [W-1:0]     onehot,
    output logic [IDX_W-1:0] idx
);

    logic [W:0] seen;

    assign seen[0] = 1'b0;

    // Prefix-OR chain: a bit wins only if no lower bit is set.
    for (genvar i = 0; i < W; i++) begin : g_chain
        assign seen[i+1]  = seen[i] | vec[i];
        assign onehot[i]  = vec[i] & ~seen[i];
    end

    assign found = seen[W];

    // Encode the one-hot winner into a binary index.
    always_comb begin
        idx = '0;
        for (int i = 0; i < W; i++) begin
            if (onehot[i]) idx |= IDX_W'(i);
        end
    end

endmodule

// File: rtl/hp_csr.sv
// Register port decode: maps word addresses onto the slot masks for reads
// and turns writes into eject and flag-clear requests.
// Assumes NUM_SLOTS <= 32; reads are combinational on reg_addr.
module hp_csr
    import hp_pkg::*;
#(
    parameter int NUM_SLOTS = 32
) (
    input  logic [2:0]           reg_addr,
    input  logic                 reg_wr,
    input  logic [DATA_W-1:0]    reg_wdata,
    input  logic [NUM_SLOTS-1:0] present,
    input  logic [NUM_SLOTS-1:0] down,
    input  logic [NUM_SLOTS-1:0] enable,
    input  logic                 gpe,
    output logic [DATA_W-1:0]    reg_rdata,
    output logic                 ej_wr,
    output logic [NUM_SLOTS-1:0] ej_val,
    output logic                 gpe_clr
);

    logic wdata_unused;
    assign wdata_unused = ^reg_wdata;

    // Write decode: eject mask and flag clear.
    assign ej_wr   = reg_wr && (reg_addr == CSR_EJECT);
    assign ej_val  = reg_wdata[NUM_SLOTS-1:0];
    assign gpe_clr = reg_wr && (reg_addr == CSR_GPE) && reg_wdata[GPE_BIT];

    // Read multiplexer; unmapped and eject words return zero.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            CSR_UP:   reg_rdata[NUM_SLOTS-1:0] = present & enable;
            CSR_DOWN: reg_rdata[NUM_SLOTS-1:0] = down;
            CSR_RMV:  reg_rdata[NUM_SLOTS-1:0] = enable;
            CSR_GPE:  reg_rdata[GPE_BIT]       = gpe;
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/hp_slot_tracker.sv
// Slot state keeper: present, pending-removal and removable masks, the
// hotplug event flag, eject servicing and the drain/rebuild sequence.
// Assumes one event per cycle; during a drain all other requests are dropped.
module hp_slot_tracker
    import hp_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ev_valid,
    input  logic [1:0]           ev_kind,
    input  logic [SLOT_W-1:0]    ev_slot,
    input  logic [NUM_SLOTS-1:0] fixed_mask,
    input  logic [NUM_SLOTS-1:0] occupied,
    input  logic                 plat_reset_req,
    input  logic                 ej_wr,
    input  logic [NUM_SLOTS-1:0] ej_val,
    input  logic                 gpe_clr,
    output logic [NUM_SLOTS-1:0] present_q,
    output logic [NUM_SLOTS-1:0] down_q,
    output logic [NUM_SLOTS-1:0] enable_q,
    output logic                 gpe_q,
    output logic                 busy,
    output logic                 eject_strobe,
    output logic [SLOT_W-1:0]    eject_slot
);

    localparam logic [31:0] SLOT_LIMIT = 32'(NUM_SLOTS);

    hp_state_e              state_q, state_d;
    logic [NUM_SLOTS-1:0]   present_d, down_d, enable_d;
    logic                   gpe_d, strobe_d;
    logic [SLOT_W-1:0]      slot_d;
    logic [NUM_SLOTS-1:0]   pick_src, pick_oh, ev_bit;
    logic                   pick_found, ev_ok;
    logic [SLOT_W-1:0]      pick_idx;
    hp_ev_e                 kind;

    assign busy = (state_q == ST_DRAIN);
    assign kind = hp_ev_e'(ev_kind);

    // One picker serves both firmware ejects and the drain sequence.
    assign pick_src = busy ? down_q : ej_val;

    hp_lsb_pick #(
        .W     (NUM_SLOTS),
        .IDX_W (SLOT_W)
    ) u_pick (
        .vec    (pick_src),
        .found  (pick_found),
        .onehot (pick_oh),
        .idx    (pick_idx)
    );

    // Qualify the event and form its slot bit.
    assign ev_ok  = ev_valid && (kind != EV_RSVD) && (32'(ev_slot) < SLOT_LIMIT);
    assign ev_bit = NUM_SLOTS'(1) << ev_slot;

    // Next-state: ejects first, then events, so an event wins on overlap.
    always_comb begin
        present_d = present_q;
        down_d    = down_q;
        enable_d  = enable_q;
        gpe_d     = gpe_q;
        state_d   = state_q;
        strobe_d  = 1'b0;
        slot_d    = eject_slot;
        case (state_q)
            ST_RUN: begin
                if (plat_reset_req) begin
                    state_d = ST_DRAIN;
                end else begin
                    if (ej_wr && pick_found) begin
                        down_d = down_d & ~pick_oh;
                        if (|(pick_oh & enable_q)) present_d = present_d & ~pick_oh;
                        strobe_d = 1'b1;
                        slot_d   = pick_idx;
                    end
                    if (gpe_clr) gpe_d = 1'b0;
                    if (ev_ok) begin
                        case (kind)
                            EV_COLD:   present_d = present_d | ev_bit;
                            EV_ADD: begin
                                present_d = present_d | ev_bit;
                                gpe_d     = 1'b1;
                            end
                            EV_REMOVE: begin
                                down_d = down_d | ev_bit;
                                gpe_d  = 1'b1;
                            end
                            default: ;
                        endcase
                    end
                end
            end
            ST_DRAIN: begin
                if (pick_found) begin
                    down_d = down_q & ~pick_oh;
                    if (|(pick_oh & enable_q)) present_d = present_q & ~pick_oh;
                    strobe_d = 1'b1;
                    slot_d   = pick_idx;
                end else begin
                    enable_d  = ~fixed_mask;
                    present_d = occupied;
                    state_d   = ST_RUN;
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    // State registers with synchronous reset loading the board inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            present_q    <= occupied;
            enable_q     <= ~fixed_mask;
            down_q       <= '0;
            gpe_q        <= 1'b0;
            state_q      <= ST_RUN;
            eject_strobe <= 1'b0;
            eject_slot   <= '0;
        end else begin
            present_q    <= present_d;
            enable_q     <= enable_d;
            down_q       <= down_d;
            gpe_q        <= gpe_d;
            state_q      <= state_d;
            eject_strobe <= strobe_d;
            eject_slot   <= slot_d;
        end
    end

endmodule

// File: rtl/hp_slot_event_ctrl.sv
// Top of the slot hotplug event controller: register port decode plus the
// slot state keeper. Assumes a single clock and NUM_SLOTS between 1 and 32.
module hp_slot_event_ctrl
    import hp_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ev_valid,
    input  logic [1:0]           ev_kind,
    input  logic [SLOT_W-1:0]    ev_slot,
    input  logic [NUM_SLOTS-1:0] fixed_mask,
    input  logic [NUM_SLOTS-1:0] occupied,
    input  logic                 plat_reset_req,
    input  logic [2:0]           reg_addr,
    input  logic                 reg_wr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    output logic                 gpe_sts,
    output logic                 eject_strobe,
    output logic [SLOT_W-1:0]    eject_slot
);

    logic [NUM_SLOTS-1:0] present_q, down_q, enable_q, ej_val;
    logic                 gpe_q, busy, ej_wr, gpe_clr;

    // Register decode and read mux.
    hp_csr #(
        .NUM_SLOTS (NUM_SLOTS)
    ) u_csr (
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .present   (present_q),
        .down      (down_q),
        .enable    (enable_q),
        .gpe       (gpe_q),
        .reg_rdata (reg_rdata),
        .ej_wr     (ej_wr),
        .ej_val    (ej_val),
        .gpe_clr   (gpe_clr)
    );

    // Slot masks, flag and eject sequencing.
    hp_slot_tracker #(
        .NUM_SLOTS (NUM_SLOTS),
        .SLOT_W    (SLOT_W)
    ) u_track (
        .clk            (clk),
        .rst_n          (rst_n),
        .ev_valid       (ev_valid),
        .ev_kind        (ev_kind),
        .ev_slot        (ev_slot),
        .fixed_mask     (fixed_mask),
        .occupied       (occupied),
        .plat_reset_req (plat_reset_req),
        .ej_wr          (ej_wr),
        .ej_val         (ej_val),
        .gpe_clr        (gpe_clr),
        .present_q      (present_q),
        .down_q         (down_q),
        .enable_q       (enable_q),
        .gpe_q          (gpe_q),
        .busy           (busy),
        .eject_strobe   (eject_strobe),
        .eject_slot     (eject_slot)
    );

    assign gpe_sts = gpe_q;

endmodule

// File: rtl/hp_slot_event_ctrl_chk.sv
// Property checker for the slot hotplug event controller, bound to the top.
// Observes ports plus the tracker's mask registers and drain indicator.
module hp_slot_event_ctrl_chk
    import hp_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ev_valid,
    input logic [1:0]           ev_kind,
    input logic [SLOT_W-1:0]    ev_slot,
    input logic                 plat_reset_req,
    input logic [2:0]           reg_addr,
    input logic                 reg_wr,
    input logic [31:0]          reg_wdata,
    input logic                 gpe_sts,
    input logic                 eject_strobe,
    input logic [SLOT_W-1:0]    eject_slot,
    input logic [NUM_SLOTS-1:0] present_q,
    input logic [NUM_SLOTS-1:0] down_q,
    input logic                 busy
);

    localparam logic [31:0] SLOT_LIMIT = 32'(NUM_SLOTS);

    logic wdata_unused;
    logic in_range, quiet;
    assign wdata_unused = ^reg_wdata;
    assign in_range = 32'(ev_slot) < SLOT_LIMIT;
    assign quiet    = !busy && !plat_reset_req;

    AST_ADD_RAISES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_kind == EV_ADD && in_range && quiet)
        |=> (gpe_sts && present_q[$past(ev_slot)])); // R3

    AST_REMOVE_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_kind == EV_REMOVE && in_range && quiet)
        |=> (gpe_sts && down_q[$past(ev_slot)])); // R4

    AST_COLD_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_kind == EV_COLD && !gpe_sts && quiet && !reg_wr)
        |=> !gpe_sts); // R5

    AST_EJECT_SLOT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        eject_strobe |-> (32'(eject_slot) < SLOT_LIMIT)); // R6

    AST_EJECT_CLEARS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (eject_strobe && !($past(ev_valid) && $past(ev_kind) == EV_REMOVE))
        |-> !down_q[eject_slot]); // R6

    AST_EJECT_ZERO_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == CSR_EJECT && reg_wdata[NUM_SLOTS-1:0] == '0
         && quiet && !ev_valid)
        |=> ($stable(down_q) && !eject_strobe)); // R7

    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == CSR_GPE && reg_wdata[GPE_BIT] && !ev_valid && quiet)
        |=> !gpe_sts); // R8

    AST_DRAIN_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (down_q == '0)); // R9

endmodule

bind hp_slot_event_ctrl hp_slot_event_ctrl_chk #(
    .NUM_SLOTS (NUM_SLOTS),
    .SLOT_W    (SLOT_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .ev_valid       (ev_valid),
    .ev_kind        (ev_kind),
    .ev_slot        (ev_slot),
    .plat_reset_req (plat_reset_req),
    .reg_addr       (reg_addr),
    .reg_wr         (reg_wr),
    .reg_wdata      (reg_wdata),
    .gpe_sts        (gpe_sts),
    .eject_strobe   (eject_strobe),
    .eject_slot     (eject_slot),
    .present_q      (present_q),
    .down_q         (down_q),
    .busy           (busy)
);

// File: tb/hp_slot_event_ctrl_tb.sv
// Scoreboard bench: eject expectations are queued by the driver and
// consumed by a monitor watching the eject strobe.
module hp_slot_event_ctrl_tb;
    import hp_pkg::*;

    localparam int N  = 6;
    localparam int SW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ev_valid = 1'b0;
    logic [1:0]    ev_kind = 2'd0;
    logic [SW-1:0] ev_slot = '0;
    logic [N-1:0]  fixed_mask = 6'b100100;
    logic [N-1:0]  occupied = 6'b000110;
    logic          plat_reset_req = 1'b0;
    logic [2:0]    reg_addr = 3'd0;
    logic          reg_wr = 1'b0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          gpe_sts;
    logic          eject_strobe;
    logic [SW-1:0] eject_slot;

    int checks = 0;
    int fails  = 0;
    int exp_q[$];
    bit done = 1'b0;

    always #5 clk = ~clk;

    hp_slot_event_ctrl #(.NUM_SLOTS(N), .SLOT_W(SW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
        .ev_slot(ev_slot), .fixed_mask(fixed_mask), .occupied(occupied),
        .plat_reset_req(plat_reset_req), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .gpe_sts(gpe_sts),
        .eject_strobe(eject_strobe), .eject_slot(eject_slot)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string req);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic ev(input hp_ev_e k, input int slot);
        @(negedge clk);
        ev_valid = 1'b1; ev_kind = k; ev_slot = SW'(slot);
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic eject(input logic [31:0] d, input int exp_slot);
        if (exp_slot >= 0) exp_q.push_back(exp_slot);
        wr(CSR_EJECT, d);
    endtask

    // Monitor: every strobe must match the next queued expectation (R6 R9).
    always @(negedge clk) begin
        if (rst_n && eject_strobe) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R6 R7 R9 unexpected strobe actual=%0d expected=none", eject_slot);
            end else begin
                int e;
                e = exp_q.pop_front();
                if (int'(eject_slot) != e) begin
                    fails++;
                    $display("FAIL R6 R9 strobe slot actual=%0d expected=%0d", eject_slot, e);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state, R1 R2 read views
        rd(CSR_UP,    32'h02, "R10 R1 up");
        rd(CSR_DOWN,  32'h00, "R10 R2 down");
        rd(CSR_RMV,   32'h1B, "R10 R2 rmv");
        rd(CSR_GPE,   32'h00, "R10 flag");
        rd(CSR_EJECT, 32'h00, "R2 eject reads zero");
        rd(3'd7,      32'h00, "R2 unmapped");
        chk("R10 strobe", {31'd0, eject_strobe}, 32'd0);
        // R5 cold-plug
        ev(EV_COLD, 0);
        rd(CSR_UP,  32'h03, "R5 present");
        rd(CSR_GPE, 32'h00, "R5 no flag");
        // R3 hot-add
        ev(EV_ADD, 4);
        rd(CSR_UP,  32'h13, "R3 present");
        rd(CSR_GPE, 32'h02, "R3 flag");
        chk("R3 gpe_sts", {31'd0, gpe_sts}, 32'd1);
        // R8 clear only via bit 1
        wr(CSR_GPE, 32'h1);
        rd(CSR_GPE, 32'h02, "R8 bit0 ignored");
        wr(CSR_GPE, 32'h2);
        rd(CSR_GPE, 32'h00, "R8 clear");
        // R4 hot-remove
        ev(EV_REMOVE, 1);
        ev(EV_REMOVE, 2);
        rd(CSR_DOWN, 32'h06, "R4 pending");
        rd(CSR_UP,   32'h13, "R4 present kept");
        rd(CSR_GPE,  32'h02, "R4 flag");
        // R6 lowest bit, removable slot
        eject(32'h06, 1);
        rd(CSR_DOWN, 32'h04, "R6 pending cleared");
        rd(CSR_UP,   32'h11, "R6 present cleared");
        // R6 fixed slot
        eject(32'h04, 2);
        rd(CSR_DOWN, 32'h00, "R6 fixed pending cleared");
        // R7 zero write
        ev(EV_REMOVE, 4);
        eject(32'h0, -1);
        chk("R7 no strobe", {31'd0, eject_strobe}, 32'd0);
        rd(CSR_DOWN, 32'h10, "R7 pending unchanged");
        rd(CSR_UP,   32'h11, "R7 present unchanged");
        // R8 set wins over clear
        @(negedge clk);
        ev_valid = 1'b1; ev_kind = EV_ADD; ev_slot = 3'd3;
        reg_wr = 1'b1; reg_addr = CSR_GPE; reg_wdata = 32'h2;
        @(negedge clk);
        ev_valid = 1'b0; reg_wr = 1'b0;
        rd(CSR_GPE, 32'h02, "R8 set wins");
        rd(CSR_UP,  32'h19, "R3 second add");
        wr(CSR_GPE, 32'h2);
        // R11 ignored events
        ev(EV_ADD, 6);
        rd(CSR_UP,  32'h19, "R11 out of range");
        rd(CSR_GPE, 32'h00, "R11 out of range flag");
        ev(EV_RSVD, 0);
        rd(CSR_DOWN, 32'h10, "R11 kind 3");
        rd(CSR_GPE,  32'h00, "R11 kind 3 flag");
        // R9 drain and rebuild
        ev(EV_REMOVE, 3);
        ev(EV_REMOVE, 0);
        rd(CSR_DOWN, 32'h19, "R4 pending set");
        wr(CSR_GPE, 32'h2);
        occupied = 6'b100001;
        exp_q.push_back(0);
        exp_q.push_back(3);
        exp_q.push_back(4);
        @(negedge clk);
        plat_reset_req = 1'b1;
        @(negedge clk);
        plat_reset_req = 1'b0;
        ev_valid = 1'b1; ev_kind = EV_ADD; ev_slot = 3'd5;
        @(negedge clk);
        ev_valid = 1'b0;
        repeat (6) @(negedge clk);
        rd(CSR_DOWN, 32'h00, "R9 drained");
        rd(CSR_UP,   32'h01, "R9 present rebuilt");
        rd(CSR_RMV,  32'h1B, "R9 removable rebuilt");
        rd(CSR_GPE,  32'h00, "R11 event during drain");
        chk("R9 all strobes seen", exp_q.size(), 32'd0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule